// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block takes request lines from four DMA channels and grants exactly one of them at a time by driving that channel's acknowledge pin. Requests are first brought into the clock domain through a two-stage synchronizer. They are then adjusted for the programmed polarity and arbitrated under fixed or rotating priority. Once a grant is issued, it stays in place until the granted channel withdraws its request.

A CPU programs the block through a single write strobe with a one-bit target select. The control byte holds several settings: a global hold-off that stops new grants while channels are being reprogrammed, the priority scheme, and the active levels of the request and acknowledge pins. It also holds four flags that are only passed on to neighbouring transfer and timing logic. The second target is a set of per-channel setting registers behind one shared address. The low bits of each written byte select the channel, and the remaining bits are stored for it.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the control byte and all channel setting registers read as zero, every acknowledge pin sits at its idle level of 1, and no grant is held.
- R2: A request that becomes active at the pins produces its acknowledge on the third rising clock edge after the pin change, and not before.
- R3: When control bit 4 is 0, priority is fixed: channel 0 wins over 1, 1 over 2, and 2 over 3.
- R4: When control bit 4 is 1, priority rotates: when a grant to channel i ends, channel i+1 (wrapping from 3 to 0) becomes the highest priority and channel i the lowest.
- R5: At most one acknowledge is active at any time, and a grant stays on its channel, whatever other requests do, until that channel's request goes inactive. The grant is released on the third edge after the pin change.
- R6: While control bit 2 is 1, no new grant is issued.
- R7: Control bit 6 selects the request level: 0 means a pin at 1 is a request, and 1 means a pin at 0 is a request.
- R8: Control bit 7 selects the acknowledge level: 0 drives the granted pin to 0 and the others to 1, and 1 drives the granted pin to 1 and the others to 0.
- R9: A write with wrSel=1 stores wrData[7:2] into the setting register of channel wrData[1:0]. That register appears on modeFlat[6c+5:6c] for channel c, and the other channels are left unchanged.
- R10: Control bits 0, 1, 3 and 5 appear directly on memPairEn, addrHoldEn, compTiming and extWrite and have no effect on arbitration.
- R11: The rotation pointer changes only when a grant ends in rotating mode. Fixed mode always ranks channel 0 first, and the pointer it left behind is still in force when rotating mode is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrSel | input | 1 | Write target: 0 = control byte, 1 = channel setting registers |
| wrData | input | 8 | Write data |
| reqPin | input | 4 | Raw channel request pins |
| ackPin | output | 4 | Channel acknowledge pins, level set by control bit 7 |
| memPairEn | output | 1 | Control bit 0 flag |
| addrHoldEn | output | 1 | Control bit 1 flag |
| compTiming | output | 1 | Control bit 3 flag |
| extWrite | output | 1 | Control bit 5 flag |
| modeFlat | output | 24 | Four 6-bit channel setting registers, channel 0 in the low bits |

## Verification
The bench uses the default build: four channels, two synchronizer stages and an 8-bit write byte. This puts every rotation wrap from channel 3 back to 0 within a few grants. With that depth, the three-edge latency from pin to acknowledge is short enough to count exactly both at the start and at the end of a grant. The 6-bit setting field lets the bench check each channel slot separately in modeFlat. The table pass steps through all four combinations of request and acknowledge level under fixed priority. The directed pass drives rotation, holding of a grant, the pointer kept across a change of priority scheme, and a second reset.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Strobes passed from the arbitration control to the datapath
  typedef struct packed {
    logic active;  // a grant is currently held
    logic load;    // latch pickVec as the new grant this cycle
    logic drop;    // release the held grant this cycle
  } ctlStrobe_t;

  // Positions inside the control byte
  localparam int CMD_PAIR    = 0;
  localparam int CMD_HOLD    = 1;
  localparam int CMD_OFF     = 2;
  localparam int CMD_COMP    = 3;
  localparam int CMD_ROTATE  = 4;
  localparam int CMD_EXTWR   = 5;
  localparam int CMD_REQLOW  = 6;
  localparam int CMD_ACKHIGH = 7;
endpackage

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int MODE_W     = DATA_W - CH_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     wrSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        reqPin,
  input  ctlStrobe_t               strobe,
  input  logic [NUM_CH-1:0]        pickVec,
  output logic [NUM_CH-1:0]        reqActive,
  output logic [NUM_CH-1:0]        grantVec,
  output logic [DATA_W-1:0]        cmdReg,
  output logic [NUM_CH-1:0]        ackPin,
  output logic [NUM_CH*MODE_W-1:0] modeFlat
);
  // Request synchronizer chain
  logic [NUM_CH-1:0] syncQ [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= reqPin;
        else syncQ[s] <= syncQ[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign reqActive = syncQ[SYNC_STAGES-1] ^ {NUM_CH{cmdReg[CMD_REQLOW]}};

  // Control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdReg <= '0;
    else if (wrEn && !wrSel) cmdReg <= wrData;
  end

  // Per-channel setting registers behind one address
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      logic [MODE_W-1:0] modeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) modeQ <= '0;
        else if (wrEn && wrSel && (wrData[CH_W-1:0] == CH_W'(c)))
          modeQ <= wrData[DATA_W-1:CH_W];
      end
      assign modeFlat[c*MODE_W +: MODE_W] = modeQ;
    end
  endgenerate

  // Grant holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grantVec <= '0;
    else if (strobe.load) grantVec <= pickVec;
    else if (strobe.drop) grantVec <= '0;
  end

  assign ackPin = cmdReg[CMD_ACKHIGH] ? grantVec : ~grantVec;
endmodule

// File: rtl/dma_arb_ctl.sv
module dma_arb_ctl
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqActive,
  input  logic [NUM_CH-1:0] grantVec,
  input  logic              holdOff,
  input  logic              rotateEn,
  output ctlStrobe_t        strobe,
  output logic [NUM_CH-1:0] pickVec
);
  logic [CH_W-1:0] topPtr;
  logic [CH_W-1:0] heldIdx;
  logic [CH_W-1:0] basePtr;
  logic            found;

  assign basePtr = rotateEn ? topPtr : '0;

  // Search from basePtr upward, wrapping around
  always_comb begin
    pickVec = '0;
    found   = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      int cand;
      cand = int'(basePtr) + k;
      if (cand >= NUM_CH) cand = cand - NUM_CH;
      if (!found && reqActive[cand]) begin
        pickVec[cand] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  always_comb begin
    heldIdx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (grantVec[i]) heldIdx = CH_W'(i);
  end

  assign strobe.active = |grantVec;
  assign strobe.drop   = strobe.active && ~|(grantVec & reqActive);
  assign strobe.load   = !strobe.active && !holdOff && found;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) topPtr <= '0;
    else if (strobe.drop && rotateEn)
      topPtr <= (int'(heldIdx) == NUM_CH - 1) ? '0 : heldIdx + 1'b1;
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [7:0]  wrData,
  input  logic [3:0]  reqPin,
  output logic [3:0]  ackPin,
  output logic        memPairEn,
  output logic        addrHoldEn,
  output logic        compTiming,
  output logic        extWrite,
  output logic [23:0] modeFlat
);
  localparam int NUM_CH = 4;
  localparam int DATA_W = 8;

  ctlStrobe_t        strobe;
  logic [NUM_CH-1:0] pickVec;
  logic [NUM_CH-1:0] reqActive;
  logic [NUM_CH-1:0] grantVec;
  logic [DATA_W-1:0] cmdReg;

  dma_arb_dp #(.NUM_CH(NUM_CH), .SYNC_STAGES(2), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .reqPin(reqPin), .strobe(strobe), .pickVec(pickVec),
    .reqActive(reqActive), .grantVec(grantVec), .cmdReg(cmdReg),
    .ackPin(ackPin), .modeFlat(modeFlat)
  );

  dma_arb_ctl #(.NUM_CH(NUM_CH)) u_ctl (
    .clk(clk), .rstN(rstN), .reqActive(reqActive), .grantVec(grantVec),
    .holdOff(cmdReg[CMD_OFF]), .rotateEn(cmdReg[CMD_ROTATE]),
    .strobe(strobe), .pickVec(pickVec)
  );

  assign memPairEn  = cmdReg[CMD_PAIR];
  assign addrHoldEn = cmdReg[CMD_HOLD];
  assign compTiming = cmdReg[CMD_COMP];
  assign extWrite   = cmdReg[CMD_EXTWR];
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int MODE_W = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_CH-1:0]        reqActive,
  input logic [NUM_CH-1:0]        grantVec,
  input logic [7:0]               cmdReg,
  input logic [NUM_CH-1:0]        ackPin,
  input logic                     wrEn,
  input logic                     wrSel,
  input logic [7:0]               wrData,
  input logic [NUM_CH*MODE_W-1:0] modeFlat
);
  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((grantVec & reqActive) != '0) |=> $stable(grantVec));

  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec == '0 && cmdReg[2]) |=> grantVec == '0);

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec == '0) |=> (grantVec == '0 || (grantVec & $past(reqActive)) != '0));

  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec == '0) |-> ackPin == {NUM_CH{!cmdReg[7]}});

  // R9
  mode_ch0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && wrData[CH_W-1:0] == '0) |=>
      modeFlat[MODE_W-1:0] == $past(wrData[7:CH_W]));
endmodule

bind dma_req_arbiter dma_arb_checker #(.NUM_CH(4), .CH_W(2), .MODE_W(6)) u_chk (
  .clk(clk), .rstN(rstN), .reqActive(reqActive), .grantVec(grantVec),
  .cmdReg(cmdReg), .ackPin(ackPin), .wrEn(wrEn), .wrSel(wrSel),
  .wrData(wrData), .modeFlat(modeFlat)
);

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [7:0]  wrData = '0;
  logic [3:0]  reqPin = '0;
  logic [3:0]  ackPin;
  logic        memPairEn, addrHoldEn, compTiming, extWrite;
  logic [23:0] modeFlat;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_req_arbiter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .reqPin(reqPin), .ackPin(ackPin), .memPairEn(memPairEn),
    .addrHoldEn(addrHoldEn), .compTiming(compTiming), .extWrite(extWrite),
    .modeFlat(modeFlat)
  );

  // {control byte, request pins, expected ack pins}
  localparam logic [15:0] VECS [0:7] = '{
    16'h00_1_E, 16'h00_A_D, 16'h00_C_B, 16'h00_F_E,
    16'h40_D_D, 16'h80_8_8, 16'hC0_7_8, 16'h04_F_F
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    chk("R1 ack idle", 32'(ackPin), 32'hF);
    chk("R1 modes", 32'(modeFlat), 32'h0);
    chk("R1 flags", 32'({memPairEn, addrHoldEn, compTiming, extWrite}), 32'h0);

    // Table walk: R3 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      logic [7:0] cmd;
      logic [3:0] idle;
      cmd  = VECS[v][15:8];
      idle = cmd[6] ? 4'hF : 4'h0;
      wrReg(1'b0, cmd | 8'h04);
      reqPin = idle;
      waitN(4);
      wrReg(1'b0, cmd);
      reqPin = VECS[v][7:4];
      waitN(3);
      chk($sformatf("R3/R6/R7/R8 vector %0d", v), 32'(ackPin), 32'(VECS[v][3:0]));
    end

    // Rotating priority, latency, hold
    wrReg(1'b0, 8'h14);
    reqPin = 4'h0;
    waitN(4);
    wrReg(1'b0, 8'h10);
    reqPin = 4'hF;
    waitN(2);
    chk("R2 not before third edge", 32'(ackPin), 32'hF);
    waitN(1);
    chk("R2 grant on third edge", 32'(ackPin), 32'hE);
    reqPin = 4'hE;
    waitN(3);
    chk("R5 release on third edge", 32'(ackPin), 32'hF);
    waitN(1);
    chk("R4 next after ch0 is ch1", 32'(ackPin), 32'hD);
    reqPin = 4'hC;
    waitN(4);
    chk("R4 next after ch1 is ch2", 32'(ackPin), 32'hB);
    reqPin = 4'h8;
    waitN(4);
    chk("R4 next after ch2 is ch3", 32'(ackPin), 32'h7);
    reqPin = 4'h9;
    waitN(4);
    chk("R5 ch3 held despite ch0", 32'(ackPin), 32'h7);
    reqPin = 4'h1;
    waitN(4);
    chk("R4 wrap ch3 to ch0", 32'(ackPin), 32'hE);

    // R11: pointer now 1 after ch0 ends
    reqPin = 4'h0;
    waitN(4);
    wrReg(1'b0, 8'h00);
    reqPin = 4'h5;
    waitN(3);
    chk("R11 fixed ranks ch0 first", 32'(ackPin), 32'hE);
    reqPin = 4'h0;
    waitN(4);
    wrReg(1'b0, 8'h10);
    reqPin = 4'h5;
    waitN(3);
    chk("R11 pointer kept through fixed", 32'(ackPin), 32'hB);
    reqPin = 4'h0;
    waitN(4);

    // R9 channel setting registers
    wrReg(1'b1, 8'hAA);
    wrReg(1'b1, 8'h54);
    waitN(1);
    chk("R9 ch2 slot and others", 32'(modeFlat), 32'h02A015);
    wrReg(1'b1, 8'hFF);
    waitN(1);
    chk("R9 ch3 slot", 32'(modeFlat), 32'hFEA015);

    // R10 flags
    wrReg(1'b0, 8'h2B);
    waitN(1);
    chk("R10 flags set", 32'({memPairEn, addrHoldEn, compTiming, extWrite}), 32'hF);
    reqPin = 4'h6;
    waitN(3);
    chk("R10 flags leave fixed arbitration", 32'(ackPin), 32'hD);
    reqPin = 4'h0;
    wrReg(1'b0, 8'h08);
    waitN(1);
    chk("R10 compTiming only", 32'({memPairEn, addrHoldEn, compTiming, extWrite}), 32'h2);

    // R1 second reset
    wrReg(1'b0, 8'h90);
    rstN = 1'b0;
    waitN(2);
    chk("R1 reset clears modes", 32'(modeFlat), 32'h0);
    chk("R1 reset ack idle", 32'(ackPin), 32'hF);
    rstN = 1'b1;
    reqPin = 4'hC;
    waitN(3);
    chk("R1 fixed after reset", 32'(ackPin), 32'hB);

    finishRun();
  end
endmodule